// File: doc/BRIEF.md
# Triggered Compare-and-Clear Unit

This block sits next to a pulse counter and decides when that counter should be cleared. On each compare event it checks the counter's present value against a TOP value. If the selected condition holds, it issues a one-cycle clear pulse and sets a sticky match flag. The two sources of compare events are exclusive. One is a sample-clock tick divided by 1, 2, 4 or 8. The other is an edge of an asynchronous trigger input.

The same trigger input can also hold back the counter's own clock. A single polarity bit sets both the active trigger edge and the gating level: rising edge and block-while-high, or falling edge and block-while-low. The trigger passes through a two-stage synchronizer and a registered edge detector. The counter and the routing of the trigger signal live outside this block.

Configuration is captured into an internal register on a write strobe. Writing the register restarts the prescaler.

Top module: `trig_cmp_clr`

## Requirements
- R1: After reset the unit is disabled, divides by 1, compares count ≤ TOP, uses rising polarity and has gating off. So clr_o and match_flag_o are 0 and cnt_en_o is 1 whatever trig_i and sample_tick_i do.
- R2: In tick mode (mode code 1), a compare event occurs on every Nth sample_tick_i after the last configuration write. N is 1, 2, 4 or 8 for prescale codes 0, 1, 2, 3. The event falls in the same cycle as the tick that completes the group of N.
- R3: Compare code 0 matches when count ≤ TOP. Code 1 matches when count ≥ TOP. Code 2 matches when TOP[7:0] ≤ count ≤ TOP[15:8], with both bounds taken as unsigned. Code 3 never matches.
- R4: clr_o is high only in a compare-event cycle, and only when the compare matches in that cycle. Each event gives a single-cycle pulse.
- R5: In edge mode (mode code 2), polarity 0 triggers on a rising trig_i and polarity 1 on a falling trig_i. The clr_o cycle is the third clock cycle after the input changes. The opposite edge and sample_tick_i have no effect.
- R6: In disabled mode (mode code 0) clr_o never rises.
- R7: With gating enabled, cnt_en_o is 0 while the synchronized trigger is high (polarity 0) or low (polarity 1). It follows trig_i two clock edges later. With gating disabled cnt_en_o stays 1.
- R8: match_flag_o becomes 1 on the clock edge that ends a clr_o pulse. It holds until flag_clr_i is 1 at a clock edge with no clr_o. A new clear wins over a simultaneous clear request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Capture configuration fields |
| cfg_mode_i | input | 2 | 0 disabled, 1 tick, 2 edge, 3 treated as disabled |
| cfg_presc_i | input | 2 | Tick divider code (divide by 2^code) |
| cfg_cmp_i | input | 2 | Compare code |
| cfg_pol_i | input | 1 | Trigger polarity and gate level |
| cfg_gate_en_i | input | 1 | Enable counter-clock gating |
| sample_tick_i | input | 1 | Sample-clock tick |
| trig_i | input | 1 | Asynchronous trigger |
| count_i | input | CNT_W | Current counter value |
| top_i | input | CNT_W | TOP value |
| flag_clr_i | input | 1 | Write-one-to-clear of the match flag |
| clr_o | output | 1 | Counter clear pulse |
| match_flag_o | output | 1 | Sticky match flag |
| cnt_en_o | output | 1 | Counter clock enable (0 = gated) |

## Verification
The bench attacks the boundaries of each compare: count equal to TOP, one above it and one below it, and both range bounds. A comparator with a strict inequality or with swapped range halves would miss or spuriously clear there.

Tick runs use random tick gaps at every divider setting. A prescaler that counts clock cycles instead of ticks, or that does not restart on a configuration write, puts clears in the wrong cycles. Edge runs check the exact cycle of the clear for both polarities and confirm that the opposite edge and ticks stay silent. A synchronizer of the wrong depth, or an inverted polarity, shows up as a shifted or missing pulse.

The gate output is checked at the cycle its latency predicts. The flag is checked when a clear and a clear request arrive together.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
  typedef enum logic [1:0] {MODE_OFF = 2'd0, MODE_TICK = 2'd1, MODE_EDGE = 2'd2, MODE_RSVD = 2'd3} mode_e;
  typedef enum logic [1:0] {CMP_LE = 2'd0, CMP_GE = 2'd1, CMP_RANGE = 2'd2, CMP_RSVD = 2'd3} cmp_e;

  typedef struct packed {
    mode_e      mode;
    logic [1:0] presc;
    cmp_e       cmp;
    logic       pol;
    logic       gate_en;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{mode: MODE_OFF, presc: 2'd0, cmp: CMP_LE, pol: 1'b0, gate_en: 1'b0};
endpackage

// File: rtl/tcc_trig_sync.sv
module tcc_trig_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  input  logic pol_i,
  output logic lvl_o,
  output logic prev_o,
  output logic edge_o
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES:0] sh_q;
  logic                 edge_q;
  logic                 rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[SYNC_STAGES-1:0], trig_i};
  end

  assign lvl_o  = sh_q[LAST];
  assign prev_o = sh_q[SYNC_STAGES];
  assign rise   = lvl_o & ~prev_o;
  assign fall   = ~lvl_o & prev_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) edge_q <= 1'b0;
    else         edge_q <= pol_i ? fall : rise;
  end

  assign edge_o = edge_q;
endmodule

// File: rtl/tcc_presc.sv
module tcc_presc #(
  parameter int SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             evt_o
);
  localparam int DIV_W = (1 << SEL_W) - 1;

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] mask;

  // mask has sel_i low bits set; a group completes when all are set
  always_comb begin
    mask = '0;
    for (int i = 0; i < DIV_W; i++) mask[i] = (i < int'(sel_i));
  end

  assign evt_o = run_i & tick_i & ((cnt_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (restart_i || !run_i) cnt_q <= '0;
    else if (tick_i)             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tcc_cmp.sv
module tcc_cmp
  import tcc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] top_i,
  input  cmp_e             cmp_i,
  output logic             match_o
);
  localparam int HALF_W = CNT_W / 2;
  localparam int HI_W   = CNT_W - HALF_W;

  logic [CNT_W-1:0] lo_bound, hi_bound;

  assign lo_bound = CNT_W'(top_i[HALF_W-1:0]);
  assign hi_bound = CNT_W'(top_i[CNT_W-1 -: HI_W]);

  always_comb begin
    unique case (cmp_i)
      CMP_LE:    match_o = count_i <= top_i;
      CMP_GE:    match_o = count_i >= top_i;
      CMP_RANGE: match_o = (count_i >= lo_bound) && (count_i <= hi_bound);
      default:   match_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/trig_cmp_clr.sv
module trig_cmp_clr
  import tcc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [1:0]       cfg_mode_i,
  input  logic [1:0]       cfg_presc_i,
  input  logic [1:0]       cfg_cmp_i,
  input  logic             cfg_pol_i,
  input  logic             cfg_gate_en_i,
  input  logic             sample_tick_i,
  input  logic             trig_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] top_i,
  input  logic             flag_clr_i,
  output logic             clr_o,
  output logic             match_flag_o,
  output logic             cnt_en_o
);
  cfg_t cfg_q, cfg_d;
  logic lvl, prev, edge_evt, tick_evt, evt, match, flag_q;

  assign cfg_d = '{mode: mode_e'(cfg_mode_i), presc: cfg_presc_i, cmp: cmp_e'(cfg_cmp_i),
                   pol: cfg_pol_i, gate_en: cfg_gate_en_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_q <= CFG_RESET;
    else if (cfg_we_i) cfg_q <= cfg_d;
  end

  tcc_trig_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .trig_i(trig_i),
    .pol_i (cfg_q.pol),
    .lvl_o (lvl),
    .prev_o(prev),
    .edge_o(edge_evt)
  );

  tcc_presc #(.SEL_W(2)) i_presc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(cfg_we_i),
    .run_i    (cfg_q.mode == MODE_TICK),
    .tick_i   (sample_tick_i),
    .sel_i    (cfg_q.presc),
    .evt_o    (tick_evt)
  );

  tcc_cmp #(.CNT_W(CNT_W)) i_cmp (
    .count_i(count_i),
    .top_i  (top_i),
    .cmp_i  (cfg_q.cmp),
    .match_o(match)
  );

  always_comb begin
    unique case (cfg_q.mode)
      MODE_TICK: evt = tick_evt;
      MODE_EDGE: evt = edge_evt;
      default:   evt = 1'b0;
    endcase
  end

  assign clr_o = evt & match;

  // a fresh clear outranks the clear request
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         flag_q <= 1'b0;
    else if (clr_o)      flag_q <= 1'b1;
    else if (flag_clr_i) flag_q <= 1'b0;
  end

  assign match_flag_o = flag_q;
  assign cnt_en_o     = ~(cfg_q.gate_en & (lvl ^ cfg_q.pol));
endmodule

// File: rtl/tcc_chk.sv
module tcc_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] mode_i,
  input logic       gate_en_i,
  input logic       clr_i,
  input logic       flag_i,
  input logic       flag_clr_i,
  input logic       cnt_en_i,
  input logic       lvl_i,
  input logic       prev_i
);
  a_r6_off_no_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd0) |-> !clr_i);

  a_r7_gate_off_passes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate_en_i |-> cnt_en_i);

  a_r5_edge_needs_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd2 && clr_i) |-> $past(lvl_i != prev_i));

  a_r8_flag_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> flag_i);

  a_r8_flag_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_i && !flag_clr_i) |=> flag_i);

  a_r8_flag_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_i) |-> $past(clr_i));
endmodule

bind trig_cmp_clr tcc_chk i_tcc_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .mode_i    (cfg_q.mode),
  .gate_en_i (cfg_q.gate_en),
  .clr_i     (clr_o),
  .flag_i    (match_flag_o),
  .flag_clr_i(flag_clr_i),
  .cnt_en_i  (cnt_en_o),
  .lvl_i     (lvl),
  .prev_i    (prev)
);

// File: tb/test_trig_cmp_clr.sv
module test_trig_cmp_clr;
  localparam int CNT_W = 16;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cfg_we = 0, cfg_pol = 0, cfg_gate = 0;
  logic [1:0] cfg_mode = 0, cfg_presc = 0, cfg_cmp = 0;
  logic tick = 0, trig = 0, fclr = 0;
  logic [CNT_W-1:0] count = 0, top = 0;
  logic clr, flag, cnt_en;

  int n_chk = 0, n_fail = 0;
  int pc = 0;
  logic exp_flag = 0;
  logic [1:0] cur_mode = 0, cur_cmp = 0, cur_presc = 0;
  logic cur_pol = 0, cur_gate = 0;

  always #5 clk = ~clk;

  trig_cmp_clr #(.CNT_W(CNT_W)) i_trig_cmp_clr (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we), .cfg_mode_i(cfg_mode),
    .cfg_presc_i(cfg_presc), .cfg_cmp_i(cfg_cmp), .cfg_pol_i(cfg_pol),
    .cfg_gate_en_i(cfg_gate), .sample_tick_i(tick), .trig_i(trig),
    .count_i(count), .top_i(top), .flag_clr_i(fclr), .clr_o(clr),
    .match_flag_o(flag), .cnt_en_o(cnt_en)
  );

  function automatic logic exp_match(logic [1:0] c, logic [CNT_W-1:0] v, logic [CNT_W-1:0] t);
    case (c)
      2'd0:    return v <= t;
      2'd1:    return v >= t;
      2'd2:    return (v >= {8'h00, t[7:0]}) && (v <= {8'h00, t[15:8]});
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic exp_cnt_en(logic g, logic p, logic l);
    return !(g && (l ^ p));
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // write configuration and clear the flag during the write cycle
  task automatic cfg(logic [1:0] m, logic [1:0] p, logic [1:0] c, logic pl, logic g);
    @(negedge clk);
    cfg_we = 1; cfg_mode = m; cfg_presc = p; cfg_cmp = c; cfg_pol = pl; cfg_gate = g;
    tick = 0; fclr = 1;
    @(negedge clk);
    cfg_we = 0; fclr = 0;
    cur_mode = m; cur_presc = p; cur_cmp = c; cur_pol = pl; cur_gate = g;
    pc = 0; exp_flag = 0;
  endtask

  // one tick-mode cycle with model update
  task automatic step(string tag, logic tk, logic [CNT_W-1:0] v, logic [CNT_W-1:0] t, logic fc);
    int n;
    logic e;
    if (clk) @(negedge clk);
    tick = tk; count = v; top = t; fclr = fc;
    #1;
    n = 1 << cur_presc;
    e = (cur_mode == 2'd1) && tk && ((pc % n) == n - 1) && exp_match(cur_cmp, v, t);
    chk({tag, " clr"}, clr, e);
    chk("R8 flag", flag, exp_flag);
    if (tk) pc++;
    exp_flag = e | (exp_flag & ~fc);
    @(negedge clk);
  endtask

  // drive trig to a new level, ticks held high, observe five cycles
  task automatic edge_run(string tag, logic lvl, logic fire, logic [CNT_W-1:0] v, logic [CNT_W-1:0] t);
    logic old = trig;
    logic m = fire && exp_match(cur_cmp, v, t);
    @(negedge clk);
    fclr = 1; tick = 1; count = v; top = t;
    @(negedge clk);
    fclr = 0; trig = lvl;
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      #1;
      chk({tag, " clr"}, clr, (k == 3) && m);
      chk("R7 gate", cnt_en, exp_cnt_en(cur_gate, cur_pol, (k >= 2) ? lvl : old));
      if (k == 4) chk("R8 flag after edge", flag, m);
    end
    tick = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    int unsigned seed = 32'h1234;
    void'($urandom(seed));

    // R1 reset defaults: trig high and ticks must do nothing
    trig = 1; tick = 1; count = 0; top = 16'hffff;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); #1;
      chk("R1 clr", clr, 0);
      chk("R1 flag", flag, 0);
      chk("R1 cnt_en", cnt_en, 1);
    end
    trig = 0; tick = 0;
    repeat (4) @(negedge clk);

    // R6 disabled with gating on: edges and ticks never clear
    cfg(2'd0, 2'd0, 2'd0, 1'b0, 1'b1);
    edge_run("R6 off rise", 1'b1, 1'b0, 16'd0, 16'd5);
    edge_run("R6 off fall", 1'b0, 1'b0, 16'd0, 16'd5);

    // R3 directed boundaries at divide by 1
    cfg(2'd1, 2'd0, 2'd0, 1'b0, 1'b0);
    step("R3 le eq", 1, 16'd100, 16'd100, 0);
    step("R3 le above", 1, 16'd101, 16'd100, 0);
    step("R3 le zero", 1, 16'd0, 16'd0, 0);
    cfg(2'd1, 2'd0, 2'd1, 1'b0, 1'b0);
    step("R3 ge eq", 1, 16'd100, 16'd100, 0);
    step("R3 ge below", 1, 16'd99, 16'd100, 0);
    step("R3 ge max", 1, 16'hffff, 16'hffff, 0);
    cfg(2'd1, 2'd0, 2'd2, 1'b0, 1'b0);
    step("R3 rng lo", 1, 16'h0010, 16'h4010, 0);
    step("R3 rng hi", 1, 16'h0040, 16'h4010, 0);
    step("R3 rng under", 1, 16'h000f, 16'h4010, 0);
    step("R3 rng over", 1, 16'h0041, 16'h4010, 1);
    step("R3 rng swapped", 1, 16'h0020, 16'h1040, 0);
    cfg(2'd1, 2'd0, 2'd3, 1'b0, 1'b0);
    step("R3 rsvd", 1, 16'd0, 16'd0, 0);

    // R8 clear request coinciding with a clear
    cfg(2'd1, 2'd0, 2'd0, 1'b0, 1'b0);
    step("R8 set", 1, 16'd1, 16'd2, 0);
    step("R8 set and req", 1, 16'd1, 16'd2, 1);
    step("R8 req only", 0, 16'd1, 16'd2, 1);
    step("R8 idle", 0, 16'd1, 16'd2, 0);

    // R2 R4 random tick runs across dividers and compares
    for (int p = 0; p < 4; p++) begin
      for (int c = 0; c < 3; c++) begin
        cfg(2'd1, 2'(p), 2'(c), 1'b0, 1'b0);
        for (int i = 0; i < 40; i++) begin
          logic [CNT_W-1:0] v = CNT_W'($urandom_range(0, 300));
          logic [CNT_W-1:0] t = (c == 2) ? CNT_W'({8'($urandom_range(100, 255)), 8'($urandom_range(0, 100))})
                                         : CNT_W'($urandom_range(0, 300));
          step("R2 R4 tick", 1'($urandom_range(0, 2) != 0), v, t, 1'($urandom_range(0, 7) == 0));
        end
      end
    end

    // R5 R7 edge mode, both polarities, gating on
    cfg(2'd2, 2'd0, 2'd0, 1'b0, 1'b1);
    edge_run("R5 pol0 rise", 1'b1, 1'b1, 16'd3, 16'd9);
    edge_run("R5 pol0 fall ignored", 1'b0, 1'b0, 16'd3, 16'd9);
    edge_run("R5 pol0 rise nomatch", 1'b1, 1'b1, 16'd10, 16'd9);
    edge_run("R5 pol0 fall", 1'b0, 1'b0, 16'd3, 16'd9);
    cfg(2'd2, 2'd3, 2'd1, 1'b1, 1'b1);
    edge_run("R5 pol1 rise ignored", 1'b1, 1'b0, 16'd9, 16'd3);
    edge_run("R5 pol1 fall", 1'b0, 1'b1, 16'd9, 16'd3);
    cfg(2'd2, 2'd0, 2'd0, 1'b1, 1'b0);
    edge_run("R7 gate off rise", 1'b1, 1'b0, 16'd0, 16'd1);
    edge_run("R7 gate off fall", 1'b0, 1'b1, 16'd0, 16'd1);

    summary();
  end
endmodule